// File: doc/BRIEF.md
# Core Low-Power Phase Sequencer

This block steps a single processor core through a low-power visit and back to normal execution. Software picks a target depth while the core runs. A wait-for-interrupt trigger then starts the visit. The visit passes through an optional preparation phase that can still be abandoned, then a committed entry phase, then an idle phase of any length, then an exit phase. After that the core runs again.

Four depths are supported:

- **Light standby:** clock gated; the shared caches may also sleep.
- **Retention:** clock gated at reduced voltage, with state kept.
- **Solo power-down:** supply removed from this core only.
- **Full collapse:** like solo power-down, but it may also ask a system resource manager to shut the subsystem down, provided every core has asked for the same depth.

The preparation, entry and exit phases each last a programmed number of cycles. The visit always drops the selected depth back to light standby once it completes, so every deeper visit has to be requested again. The sequencer drives these outputs as decodes of phase and depth:

- clock gate
- retention voltage
- power switch
- cache standby
- core reset
- a level request to the resource manager

Top module: `lp_seq`

## Requirements
- R1: Reset puts the block in the running phase with light standby selected and every control output low. Phase codes are 0 run, 1 prep, 2 entry, 3 idle, 4 exit. Depth codes are 0 light standby, 1 retention, 2 solo power-down, 3 full collapse. A `wfi` pulse while running moves to prep, or straight to entry when `prep_len` is 0.
- R2: `wake_irq` high during prep returns the block to running on the next edge, and the selected depth is kept.
- R3: Entry always runs to idle whatever `wake_irq` does. A wake seen during entry is remembered, so idle then lasts exactly one cycle.
- R4: Idle lasts until `wake_irq` is seen (or a remembered wake exists), however long that takes; the next phase is exit.
- R5: Prep lasts `prep_len` cycles. Entry lasts max(`entry_len`,1) cycles. Exit lasts at least max(`exit_len`,1) cycles.
- R6: `clk_gate` is high in entry and idle. With light standby, `cache_stby` is high only in idle while `all_idle` is high. Exit then completes only once `cache_ready` is high.
- R7: With retention, `ret_volt` is high in idle, and exit does not wait for `cache_ready`.
- R8: With solo power-down, `pwr_off` is high in idle and `core_rst` is high in idle and exit. Exit waits for `cache_ready`. `rm_req` stays low even when `all_collapse` is high.
- R9: With full collapse, `rm_req` rises in idle only while `all_collapse` is high, holds until idle ends, and exit makes no progress while `rm_ack` is high.
- R10: Completing exit sets the depth back to light standby. `mode_load` is ignored outside the running phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Depth to select |
| mode_load | input | 1 | Capture `mode_req` (running phase only) |
| wfi | input | 1 | Start a low-power visit |
| wake_irq | input | 1 | Wake-up interrupt |
| prep_len | input | CNT_W | Prep length in cycles, 0 skips prep |
| entry_len | input | CNT_W | Entry length in cycles |
| exit_len | input | CNT_W | Minimum exit length in cycles |
| all_idle | input | 1 | Every core is idle |
| all_collapse | input | 1 | Every core has asked for full collapse |
| cache_ready | input | 1 | Cache hierarchy awake and ready |
| rm_ack | input | 1 | Resource manager acknowledge |
| phase_o | output | 3 | Current phase code |
| mode_o | output | 2 | Selected depth code |
| clk_gate | output | 1 | Core clock gate enable |
| ret_volt | output | 1 | Retention voltage request |
| pwr_off | output | 1 | Core power switch off |
| cache_stby | output | 1 | Cache hierarchy standby |
| core_rst | output | 1 | Core reset |
| rm_req | output | 1 | Shutdown request to resource manager |

## Verification
Each depth is taken through a full visit. The idle phase is held for several cycles and the release inputs are withheld, which separates a correct wait from an early exit. Wakes are placed in prep and in entry to tell an abandoned preparation apart from a committed entry and from a remembered wake. Collapse is run with and without the all-cores signal and with the acknowledge held high, so a missing gate on the request or on power restoration shows. A zero prep length and a zero entry length exercise the skipped and minimum-length phases.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
   typedef enum logic [2:0] {
      PH_EXEC  = 3'd0,
      PH_PREP  = 3'd1,
      PH_ENTRY = 3'd2,
      PH_IDLE  = 3'd3,
      PH_EXIT  = 3'd4
   } phase_e;

   typedef enum logic [1:0] {
      MD_STBY = 2'd0,
      MD_RET  = 2'd1,
      MD_SOLO = 2'd2,
      MD_COLL = 2'd3
   } mode_e;

   // timed phases: prep, entry, exit
   localparam int NUM_TIMED = 3;

   function automatic phase_e timed_phase(input int idx);
      case (idx)
         0:       return PH_PREP;
         1:       return PH_ENTRY;
         default: return PH_EXIT;
      endcase
   endfunction
endpackage

// File: rtl/lp_phase_timer.sv
module lp_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && (cnt_q > CNT_W'(1)))
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign done = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/lp_rm_handshake.sv
module lp_rm_handshake (
   input  logic clk,
   input  logic rst_n,
   input  logic in_idle,
   input  logic coll_mode,
   input  logic all_coll,
   input  logic leave_idle,
   output logic req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         req <= 1'b0;
      else if (leave_idle)
         req <= 1'b0;
      else if (in_idle && coll_mode && all_coll)
         req <= 1'b1;
   end
endmodule

// File: rtl/lp_out_decode.sv
module lp_out_decode
   import lp_seq_pkg::*;
(
   input  phase_e phase,
   input  mode_e  mode,
   input  logic   all_idle,
   output logic   clk_gate,
   output logic   ret_volt,
   output logic   pwr_off,
   output logic   cache_stby,
   output logic   core_rst
);
   logic in_idle, powered_down;

   always_comb begin
      in_idle      = (phase == PH_IDLE);
      powered_down = (mode == MD_SOLO) || (mode == MD_COLL);
      clk_gate     = (phase == PH_ENTRY) || in_idle;
      ret_volt     = in_idle && (mode == MD_RET);
      pwr_off      = in_idle && powered_down;
      cache_stby   = in_idle && (mode == MD_STBY) && all_idle;
      core_rst     = (in_idle || (phase == PH_EXIT)) && powered_down;
   end
endmodule

// File: rtl/lp_seq.sv
module lp_seq
   import lp_seq_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit PREP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_req,
   input  logic             mode_load,
   input  logic             wfi,
   input  logic             wake_irq,
   input  logic [CNT_W-1:0] prep_len,
   input  logic [CNT_W-1:0] entry_len,
   input  logic [CNT_W-1:0] exit_len,
   input  logic             all_idle,
   input  logic             all_collapse,
   input  logic             cache_ready,
   input  logic             rm_ack,
   output logic [2:0]       phase_o,
   output logic [1:0]       mode_o,
   output logic             clk_gate,
   output logic             ret_volt,
   output logic             pwr_off,
   output logic             cache_stby,
   output logic             core_rst,
   output logic             rm_req
);
   if (CNT_W < 2) begin : g_bad_width
      $error("lp_seq: CNT_W must be at least 2");
   end

   phase_e phase_q, phase_d;
   mode_e  mode_q;
   logic   wake_lat;
   logic   exit_hold;
   logic   skip_prep;
   logic   release_ok;
   logic   leave_idle;
   logic [NUM_TIMED-1:0] tmr_done;
   logic [CNT_W-1:0]     tmr_len [NUM_TIMED];

   assign tmr_len[0] = prep_len;
   assign tmr_len[1] = entry_len;
   assign tmr_len[2] = exit_len;

   if (PREP_EN) begin : g_prep
      assign skip_prep = (prep_len == '0);
   end else begin : g_noprep
      assign skip_prep = 1'b1;
   end

   assign exit_hold  = (phase_q == PH_EXIT) && (mode_q == MD_COLL) && rm_ack;
   assign release_ok = (mode_q == MD_RET) || cache_ready;
   assign leave_idle = (phase_q == PH_IDLE) && (phase_d == PH_EXIT);

   always_comb begin
      phase_d = phase_q;
      case (phase_q)
         PH_EXEC:  if (wfi) phase_d = skip_prep ? PH_ENTRY : PH_PREP;
         PH_PREP: begin
            if (wake_irq)         phase_d = PH_EXEC;
            else if (tmr_done[0]) phase_d = PH_ENTRY;
         end
         PH_ENTRY: if (tmr_done[1]) phase_d = PH_IDLE;
         PH_IDLE:  if (wake_irq || wake_lat) phase_d = PH_EXIT;
         PH_EXIT:  if (!exit_hold && tmr_done[2] && release_ok) phase_d = PH_EXEC;
         default:  phase_d = PH_EXEC;
      endcase
   end

   for (genvar i = 0; i < NUM_TIMED; i++) begin : g_tmr
      localparam phase_e TP = timed_phase(i);
      lp_phase_timer #(.CNT_W(CNT_W)) u_tmr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     ((phase_d == TP) && (phase_q != TP)),
         .load_val (tmr_len[i]),
         .dec      ((phase_q == TP) && !exit_hold),
         .done     (tmr_done[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_EXEC;
         mode_q   <= MD_STBY;
         wake_lat <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if ((phase_q == PH_EXEC) && mode_load)
            mode_q <= mode_e'(mode_req);
         else if ((phase_q == PH_EXIT) && (phase_d == PH_EXEC))
            mode_q <= MD_STBY;
         if (leave_idle)
            wake_lat <= 1'b0;
         else if ((phase_q == PH_ENTRY) && wake_irq)
            wake_lat <= 1'b1;
      end
   end

   lp_rm_handshake u_rm (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_idle    (phase_q == PH_IDLE),
      .coll_mode  (mode_q == MD_COLL),
      .all_coll   (all_collapse),
      .leave_idle (leave_idle),
      .req        (rm_req)
   );

   lp_out_decode u_dec (
      .phase      (phase_q),
      .mode       (mode_q),
      .all_idle   (all_idle),
      .clk_gate   (clk_gate),
      .ret_volt   (ret_volt),
      .pwr_off    (pwr_off),
      .cache_stby (cache_stby),
      .core_rst   (core_rst)
   );

   assign phase_o = phase_q;
   assign mode_o  = mode_q;
endmodule

// File: rtl/lp_seq_chk.sv
module lp_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] phase,
   input logic [1:0] cur_mode,
   input logic       wake_irq,
   input logic       wake_lat,
   input logic       rm_ack,
   input logic       rm_req,
   input logic       ret_volt,
   input logic       pwr_off,
   input logic       cache_stby
);
   a_r2_prep_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd1 && wake_irq) |=> (phase == 3'd0));

   a_r3_entry_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd2) |=> (phase == 3'd2 || phase == 3'd3));

   a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd3 && !wake_irq && !wake_lat) |=> (phase == 3'd3));

   a_r9_req_collapse: assert property (@(posedge clk) disable iff (!rst_n)
      rm_req |-> (cur_mode == 2'd3 && phase == 3'd3));

   a_r9_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd4 && cur_mode == 2'd3 && rm_ack) |=> (phase == 3'd4));

   a_r10_fallback: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd4) |=> (phase != 3'd0 || cur_mode == 2'd0));

   a_r6_one_depth: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ret_volt, pwr_off, cache_stby}));
endmodule

bind lp_seq lp_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .phase      (phase_o),
   .cur_mode   (mode_o),
   .wake_irq   (wake_irq),
   .wake_lat   (wake_lat),
   .rm_ack     (rm_ack),
   .rm_req     (rm_req),
   .ret_volt   (ret_volt),
   .pwr_off    (pwr_off),
   .cache_stby (cache_stby)
);

// File: tb/sim_lp_seq.sv
module sim_lp_seq;
   localparam int CW = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0;
   logic [1:0] mode_req = '0;
   logic mode_load = 0, wfi = 0, wake_irq = 0;
   logic [CW-1:0] prep_len = 8'd2, entry_len = 8'd3, exit_len = 8'd2;
   logic all_idle = 0, all_collapse = 0, cache_ready = 0, rm_ack = 0;
   logic [2:0] phase_o;
   logic [1:0] mode_o;
   logic clk_gate, ret_volt, pwr_off, cache_stby, core_rst, rm_req;

   lp_seq #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_load(mode_load),
      .wfi(wfi), .wake_irq(wake_irq), .prep_len(prep_len), .entry_len(entry_len),
      .exit_len(exit_len), .all_idle(all_idle), .all_collapse(all_collapse),
      .cache_ready(cache_ready), .rm_ack(rm_ack), .phase_o(phase_o), .mode_o(mode_o),
      .clk_gate(clk_gate), .ret_volt(ret_volt), .pwr_off(pwr_off),
      .cache_stby(cache_stby), .core_rst(core_rst), .rm_req(rm_req));

   int checks = 0, fails = 0, cyc = 0;
   string tag = "R1";

   // behavioural reference
   int m_ph = 0, m_cnt = 0, m_mode = 0;
   bit m_wl = 0, m_rq = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_mode = 0; m_wl = 0; m_rq = 0;
      end else begin
         case (m_ph)
            0: begin
               if (mode_load) m_mode = int'(mode_req);
               if (wfi) begin
                  if (prep_len == 0) begin m_ph = 2; m_cnt = int'(entry_len); end
                  else begin m_ph = 1; m_cnt = int'(prep_len); end
               end
            end
            1: begin
               if (wake_irq) m_ph = 0;
               else if (m_cnt <= 1) begin m_ph = 2; m_cnt = int'(entry_len); end
               else m_cnt--;
            end
            2: begin
               if (wake_irq) m_wl = 1;
               if (m_cnt <= 1) m_ph = 3;
               else m_cnt--;
            end
            3: begin
               if (wake_irq || m_wl) begin
                  m_ph = 4; m_cnt = int'(exit_len); m_wl = 0; m_rq = 0;
               end else if (m_mode == 3 && all_collapse) m_rq = 1;
            end
            default: begin
               if (!(m_mode == 3 && rm_ack)) begin
                  if (m_cnt <= 1 && (m_mode == 1 || cache_ready)) begin
                     m_ph = 0; m_mode = 0;
                  end else if (m_cnt > 1) m_cnt--;
               end
            end
         endcase
      end
   end

   function automatic logic [10:0] model_out();
      bit pd = (m_mode == 2 || m_mode == 3);
      return {3'(m_ph), 2'(m_mode),
              1'(m_ph == 2 || m_ph == 3),
              1'(m_ph == 3 && m_mode == 1),
              1'(m_ph == 3 && pd),
              1'(m_ph == 3 && m_mode == 0 && all_idle),
              1'((m_ph == 3 || m_ph == 4) && pd),
              1'(m_rq)};
   endfunction

   task automatic chk(input string t, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", t, act, exp, cyc);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(tag, int'({phase_o, mode_o, clk_gate, ret_volt, pwr_off,
                        cache_stby, core_rst, rm_req}), int'(model_out()));
      end
   endtask

   task automatic pulse_wfi();
      wfi = 1; tick(); wfi = 0;
   endtask

   task automatic pulse_wake();
      wake_irq = 1; tick(); wake_irq = 0;
   endtask

   task automatic select(input logic [1:0] m);
      mode_req = m; mode_load = 1; tick(); mode_load = 0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1;
      tag = "R1"; tick();
      chk("R1", int'(phase_o), 0);
      chk("R1", int'({clk_gate, ret_volt, pwr_off, cache_stby, core_rst, rm_req}), 0);

      // light standby visit, caches slow to return
      tag = "R6"; all_idle = 1;
      pulse_wfi(); tick(8); all_idle = 0; tick(2); all_idle = 1;
      pulse_wake(); tick(4); cache_ready = 1; tick(3);
      chk("R6", int'(phase_o), 0);

      // retention ignores cache_ready
      tag = "R7"; cache_ready = 0;
      select(2'd1); pulse_wfi(); tick(7); pulse_wake(); tick(4);
      chk("R10", int'(mode_o), 0);

      // solo power-down with all_collapse high: no request
      tag = "R8"; all_collapse = 1;
      select(2'd2); pulse_wfi(); tick(8);
      chk("R8", int'(rm_req), 0);
      pulse_wake(); tick(3); cache_ready = 1; tick(3);

      // full collapse with handshake
      tag = "R9";
      select(2'd3); pulse_wfi(); tick(8);
      chk("R9", int'(rm_req), 1);
      rm_ack = 1; tick(2); pulse_wake(); tick(4);
      chk("R9", int'(phase_o), 4);
      rm_ack = 0; tick(4);

      // full collapse without all cores
      all_collapse = 0;
      select(2'd3); pulse_wfi(); tick(8);
      chk("R9", int'(rm_req), 0);
      pulse_wake(); tick(4);

      // prep abort keeps depth
      tag = "R2"; prep_len = 8'd4;
      select(2'd1); pulse_wfi();
      chk("R2", int'(phase_o), 1);
      pulse_wake();
      chk("R2", int'(phase_o), 0);
      chk("R2", int'(mode_o), 1);
      tick(2);

      // wake during entry is latched
      tag = "R3"; prep_len = 8'd0; entry_len = 8'd4;
      pulse_wfi();
      chk("R5", int'(phase_o), 2);
      pulse_wake();
      chk("R3", int'(phase_o), 2);
      tick(2);
      chk("R3", int'(phase_o), 2);
      tick();
      chk("R3", int'(phase_o), 3);
      tick();
      chk("R3", int'(phase_o), 4);
      tick(4);

      // zero entry length, long idle, mode_load ignored in idle
      tag = "R4"; entry_len = 8'd0; exit_len = 8'd5;
      pulse_wfi(); tick(2);
      tag = "R10"; select(2'd2); tick(20);
      chk("R4", int'(phase_o), 3);
      chk("R10", int'(mode_o), 0);
      tag = "R5"; pulse_wake(); tick(8);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule